// File: doc/BRIEF.md
# Serial Burst Master (SPI / Microwire)

This block drives a synchronous serial slave as the only master on the link. Each start command sends one to four words and receives the same number, full-duplex, one word straight after the other. The word length is any value from 1 to 32 bits. The host chooses the bit order, the idle level of the serial clock, the clock edge that launches outgoing data, the clock edge that samples incoming data, and which of two active-low select lines is used.

The serial clock is divided down from the system clock by a 16-bit divider, and every signal changes on system clock edges in one clock domain. The host puts up to four transmit words and a configuration on the input ports, then pulses start. The block copies the configuration and the words, and holds busy high until the burst ends. It then raises a sticky completion interrupt and keeps the received words on its outputs until the next start.

Top module: `spi_burst_master`

## Requirements
- R1: While idle, `sclk_o` follows `cpol_i` one cycle later. During a burst, every clock half-period lasts `div_i`+1 system cycles.
- R2: In the cycle after start is accepted, the select line at index `ss_sel_i` goes low and the other line stays high. The first clock edge comes `div_i`+1 cycles after the select falls, and the select rises `div_i`+1 cycles after the last clock edge.
- R3: A burst makes exactly 2 x L x N clock edges, where L = `len_m1_i`+1 is the word length and N = `words_m1_i`+1 is the word count. After those edges `sclk_o` is back at its idle level.
- R4: Received word k appears on `rx_data_o[32k+L-1:32k]` with every higher bit zero. Words beyond N read zero.
- R5: Words go out and come in back to back in index order, word 0 first. Word k of the burst uses `tx_data_i[32k+31:32k]`.
- R6: `lsb_first_i`=1 sends and stores bit 0 of each word first. `lsb_first_i`=0 sends and stores bit L-1 first.
- R7: The first bit is on `mosi_o` from the cycle the select falls. `mosi_o` then changes only on clock edges of the launch type (falling if `tx_fall_i`=1, rising if 0), never on the first edge of the burst.
- R8: `miso_i` is sampled on every clock edge of the sample type (falling if `rx_fall_i`=1, rising if 0), which gives L x N samples per burst.
- R9: `busy_o` rises in the cycle after start is accepted and falls when the select rises. A start pulse while busy has no effect on the burst, its data or its timing.
- R10: `irq_o` goes high when `busy_o` falls and stays high until `irq_clr_i`. When both happen in the same cycle, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse (go) |
| irq_clr_i | input | 1 | Clears the completion flag |
| div_i | input | 16 | Half-period length minus one, in system cycles |
| len_m1_i | input | 5 | Word length minus one |
| words_m1_i | input | 2 | Words per burst minus one |
| lsb_first_i | input | 1 | 1: LSB first, 0: MSB first |
| cpol_i | input | 1 | Idle level of the serial clock |
| tx_fall_i | input | 1 | 1: launch on falling edges, 0: on rising edges |
| rx_fall_i | input | 1 | 1: sample on falling edges, 0: on rising edges |
| ss_sel_i | input | 1 | Index of the select line to use |
| tx_data_i | input | 128 | Four transmit words, word k in bits 32k+31..32k |
| miso_i | input | 1 | Serial data from the slave |
| busy_o | output | 1 | Burst in progress |
| irq_o | output | 1 | Sticky completion flag |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| ss_n_o | output | 2 | Active-low slave selects |
| rx_data_o | output | 128 | Four received words |

## Verification
Some rules hold on every cycle, and the bound checker tests them there:
- at most one select line is low;
- both select lines are high whenever the block is idle;
- the idle clock tracks the polarity input;
- `mosi_o` never moves while the serial clock is steady inside a burst;
- the completion flag rises only as busy falls, and it stays high until cleared.

The values that depend on the configuration can only be shown by scenarios with a behavioural slave. These are the bit order, the word length and the alignment, the launch and sample edge choices, the lead and tail spacing of the select, the exact edge count, and the fact that a start pulse during a burst is ignored. The bench covers them across different dividers, word lengths, word counts, polarities and edge combinations.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} xfer_state_t;

  typedef struct packed {
    logic lsb_first;
    logic tx_fall;
    logic rx_fall;
  } shift_mode_t;
endpackage

// File: rtl/spi_half_ticker.sv
module spi_half_ticker #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == div) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_bit_pointer.sv
module spi_bit_pointer #(
  parameter int LEN_W = 5,
  parameter int WIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WIDX_W-1:0] load_word,
  input  logic [LEN_W-1:0]  load_bit,
  input  logic              step,
  input  logic [LEN_W-1:0]  last_bit,
  output logic [WIDX_W-1:0] word_q,
  output logic [LEN_W-1:0]  bit_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      bit_q  <= '0;
    end else if (load) begin
      word_q <= load_word;
      bit_q  <= load_bit;
    end else if (step) begin
      if (bit_q == last_bit) begin
        bit_q  <= '0;
        word_q <= word_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MAX_WORDS = 4,
  parameter int DIV_W     = 16,
  parameter int NUM_SS    = 2,
  localparam int LEN_W    = $clog2(DATA_W),
  localparam int CNT_W    = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
  localparam int SEL_W    = (NUM_SS > 1) ? $clog2(NUM_SS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_i,
  input  logic                        irq_clr_i,
  input  logic [DIV_W-1:0]            div_i,
  input  logic [LEN_W-1:0]            len_m1_i,
  input  logic [CNT_W-1:0]            words_m1_i,
  input  logic                        lsb_first_i,
  input  logic                        cpol_i,
  input  logic                        tx_fall_i,
  input  logic                        rx_fall_i,
  input  logic [SEL_W-1:0]            ss_sel_i,
  input  logic [MAX_WORDS*DATA_W-1:0] tx_data_i,
  input  logic                        miso_i,
  output logic                        busy_o,
  output logic                        irq_o,
  output logic                        sclk_o,
  output logic                        mosi_o,
  output logic [NUM_SS-1:0]           ss_n_o,
  output logic [MAX_WORDS*DATA_W-1:0] rx_data_o
);
  localparam int EDGE_W = $clog2(2 * DATA_W * MAX_WORDS + 1);

  xfer_state_t                          state_q;
  shift_mode_t                          mode_q;
  logic [DIV_W-1:0]                     div_q;
  logic [LEN_W-1:0]                     len_m1_q;
  logic [EDGE_W-1:0]                    edge_cnt_q;
  logic [EDGE_W-1:0]                    edge_total_q;
  logic [MAX_WORDS-1:0][DATA_W-1:0]     tx_mem_q;
  logic [MAX_WORDS-1:0][DATA_W-1:0]     rx_mem_q;

  logic              accept, tick, edge_now, finish, is_fall, launch, sample;
  logic [CNT_W-1:0]  tx_word, rx_word;
  logic [LEN_W-1:0]  tx_bit, rx_bit;
  logic [CNT_W-1:0]  tx_init_word;
  logic [LEN_W-1:0]  tx_init_bit;

  function automatic logic [LEN_W-1:0] pos_of(input logic lsb,
                                               input logic [LEN_W-1:0] lm1,
                                               input logic [LEN_W-1:0] b);
    return lsb ? b : (lm1 - b);
  endfunction

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign edge_now = tick && (edge_cnt_q != edge_total_q);
  assign finish   = tick && (edge_cnt_q == edge_total_q);
  assign is_fall  = sclk_o;
  assign launch   = edge_now && (is_fall == mode_q.tx_fall) && (edge_cnt_q != '0);
  assign sample   = edge_now && (is_fall == mode_q.rx_fall);

  // transmit pointer runs one bit ahead of the bit on the line
  assign tx_init_word = (len_m1_i == '0) ? CNT_W'(1) : '0;
  assign tx_init_bit  = (len_m1_i == '0) ? '0 : LEN_W'(1);

  spi_half_ticker #(.DIV_W(DIV_W)) u_ticker (
    .clk (clk),
    .rst (rst),
    .run (state_q == ST_RUN),
    .div (div_q),
    .tick(tick)
  );

  spi_bit_pointer #(.LEN_W(LEN_W), .WIDX_W(CNT_W)) u_tx_ptr (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_word(tx_init_word),
    .load_bit (tx_init_bit),
    .step     (launch),
    .last_bit (len_m1_q),
    .word_q   (tx_word),
    .bit_q    (tx_bit)
  );

  spi_bit_pointer #(.LEN_W(LEN_W), .WIDX_W(CNT_W)) u_rx_ptr (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_word('0),
    .load_bit ('0),
    .step     (sample),
    .last_bit (len_m1_q),
    .word_q   (rx_word),
    .bit_q    (rx_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      mode_q       <= '0;
      div_q        <= '0;
      len_m1_q     <= '0;
      edge_cnt_q   <= '0;
      edge_total_q <= '0;
      busy_o       <= 1'b0;
      sclk_o       <= cpol_i;
      mosi_o       <= 1'b0;
      ss_n_o       <= '1;
    end else if (accept) begin
      state_q      <= ST_RUN;
      mode_q       <= '{lsb_first: lsb_first_i, tx_fall: tx_fall_i, rx_fall: rx_fall_i};
      div_q        <= div_i;
      len_m1_q     <= len_m1_i;
      edge_cnt_q   <= '0;
      edge_total_q <= EDGE_W'(2 * (32'(len_m1_i) + 1) * (32'(words_m1_i) + 1));
      busy_o       <= 1'b1;
      sclk_o       <= cpol_i;
      mosi_o       <= tx_data_i[pos_of(lsb_first_i, len_m1_i, '0)];
      for (int i = 0; i < NUM_SS; i++) begin
        ss_n_o[i] <= (SEL_W'(i) != ss_sel_i);
      end
    end else if (state_q == ST_IDLE) begin
      sclk_o <= cpol_i;
    end else if (finish) begin
      state_q <= ST_IDLE;
      busy_o  <= 1'b0;
      ss_n_o  <= '1;
    end else if (edge_now) begin
      edge_cnt_q <= edge_cnt_q + 1'b1;
      sclk_o     <= ~sclk_o;
      if (launch) begin
        mosi_o <= tx_mem_q[tx_word][pos_of(mode_q.lsb_first, len_m1_q, tx_bit)];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_mem_q <= '0;
      rx_mem_q <= '0;
    end else if (accept) begin
      tx_mem_q <= tx_data_i;
      rx_mem_q <= '0;
    end else if (sample) begin
      rx_mem_q[rx_word][pos_of(mode_q.lsb_first, len_m1_q, rx_bit)] <= miso_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
    end else if (finish) begin
      irq_o <= 1'b1;
    end else if (irq_clr_i) begin
      irq_o <= 1'b0;
    end
  end

  assign rx_data_o = rx_mem_q;
endmodule

// File: rtl/spi_burst_master_sva.sv
module spi_burst_master_sva #(
  parameter int NUM_SS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_clr_i,
  input logic              cpol_i,
  input logic              busy_o,
  input logic              irq_o,
  input logic              sclk_o,
  input logic              mosi_o,
  input logic [NUM_SS-1:0] ss_n_o
);
  a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ss_n_o));

  a_r2_idle_deselect: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (ss_n_o == '1));

  a_r1_idle_clock_level: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && $past(!busy_o)) |-> (sclk_o == $past(cpol_i)));

  a_r7_mosi_only_on_edges: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o) && $stable(sclk_o)) |-> $stable(mosi_o));

  a_r10_irq_at_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> irq_o);

  a_r10_irq_rise_only_at_done: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $fell(busy_o));

  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !irq_clr_i) |=> irq_o);
endmodule

bind spi_burst_master spi_burst_master_sva #(.NUM_SS(NUM_SS)) u_sva (
  .clk      (clk),
  .rst      (rst),
  .irq_clr_i(irq_clr_i),
  .cpol_i   (cpol_i),
  .busy_o   (busy_o),
  .irq_o    (irq_o),
  .sclk_o   (sclk_o),
  .mosi_o   (mosi_o),
  .ss_n_o   (ss_n_o)
);

// File: tb/spi_burst_master_tb.sv
`timescale 1ns/1ps
module spi_burst_master_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0, irq_clr_i = 1'b0;
  logic [15:0]  div_i = '0;
  logic [4:0]   len_m1_i = '0;
  logic [1:0]   words_m1_i = '0;
  logic         lsb_first_i = 1'b0, cpol_i = 1'b0, tx_fall_i = 1'b1, rx_fall_i = 1'b0;
  logic         ss_sel_i = 1'b0;
  logic [127:0] tx_data_i = '0;
  logic         miso_i = 1'b0;
  logic         busy_o, irq_o, sclk_o, mosi_o;
  logic [1:0]   ss_n_o;
  logic [127:0] rx_data_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  spi_burst_master dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .irq_clr_i(irq_clr_i),
    .div_i(div_i), .len_m1_i(len_m1_i), .words_m1_i(words_m1_i),
    .lsb_first_i(lsb_first_i), .cpol_i(cpol_i), .tx_fall_i(tx_fall_i),
    .rx_fall_i(rx_fall_i), .ss_sel_i(ss_sel_i), .tx_data_i(tx_data_i),
    .miso_i(miso_i), .busy_o(busy_o), .irq_o(irq_o), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .ss_n_o(ss_n_o), .rx_data_o(rx_data_o)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // slave model state and data shared with the scoreboard
  logic [127:0] sl_data = '0, cap_flat = '0;
  int  cur_len = 1, cur_nw = 1;
  bit  cur_lsb = 0;
  int  edge_n = 0, mi = 0, ci = 0, cyc = 0;
  int  t_fall = 0, t_first = 0, t_last = 0, t_rise = 0;
  bit  prev_s = 1, prev_sclk = 0, prev_busy = 0;

  int           q_nw[$], q_len[$], q_div[$];
  logic [31:0]  q_rx[$], q_tx[$];

  function automatic logic bit_at(input logic [127:0] d, input int idx, input int len,
                                  input int nw, input bit lsb);
    int w, b;
    if (idx >= len * nw) return 1'b0;
    w = idx / len;
    b = idx % len;
    return d[w * 32 + (lsb ? b : len - 1 - b)];
  endfunction

  function automatic logic [31:0] mask_of(input int len);
    return (len == 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
  endfunction

  // behavioural slave plus monitor, all on the falling edge of clk
  always @(negedge clk) begin
    bit s, fall;
    cyc++;
    s = ss_n_o[ss_sel_i];
    if (!rst && busy_o) begin
      check(ss_n_o[!ss_sel_i] == 1'b1, "R2 unused select high", ss_n_o, 2'b11);
    end
    if (prev_s && !s) begin
      edge_n = 0; mi = 0; ci = 0; cap_flat = '0; t_fall = cyc;
      miso_i = bit_at(sl_data, 0, cur_len, cur_nw, cur_lsb);
    end else if (!s && sclk_o != prev_sclk) begin
      fall = !sclk_o;
      if (edge_n == 0) t_first = cyc;
      t_last = cyc;
      if (fall != tx_fall_i) begin
        if (ci < cur_len * cur_nw)
          cap_flat[(ci / cur_len) * 32 + (cur_lsb ? ci % cur_len : cur_len - 1 - ci % cur_len)] = mosi_o;
        ci++;
      end
      if (fall != rx_fall_i && edge_n != 0) begin
        mi++;
        miso_i = bit_at(sl_data, mi, cur_len, cur_nw, cur_lsb);
      end
      edge_n++;
    end
    if (!prev_s && s) t_rise = cyc;
    // scoreboard: a burst ended in this cycle
    if (prev_busy && !busy_o && q_nw.size() > 0) begin
      int nw, len, dv;
      nw = q_nw.pop_front(); len = q_len.pop_front(); dv = q_div.pop_front();
      for (int w = 0; w < 4; w++) begin
        logic [31:0] er, et;
        er = (w < nw) ? q_rx.pop_front() : 32'h0;
        et = (w < nw) ? q_tx.pop_front() : 32'h0;
        check(rx_data_o[w*32 +: 32] == er, "R4 R6 R8 received word", rx_data_o[w*32 +: 32], er);
        if (w < nw)
          check(cap_flat[w*32 +: 32] == et, "R5 R6 R7 sent word", cap_flat[w*32 +: 32], et);
      end
      check(edge_n == 2 * len * nw, "R3 edge count", edge_n, 2 * len * nw);
      check(t_first - t_fall == dv + 1, "R2 lead time", t_first - t_fall, dv + 1);
      check(t_rise - t_last == dv + 1, "R2 tail time", t_rise - t_last, dv + 1);
      check(t_rise - t_fall == (2 * len * nw + 1) * (dv + 1), "R1 R9 busy length",
            t_rise - t_fall, (2 * len * nw + 1) * (dv + 1));
      check(irq_o == 1'b1, "R10 irq at done", irq_o, 1);
      check(sclk_o == cpol_i, "R3 clock back idle", sclk_o, cpol_i);
    end
    prev_s = s; prev_sclk = sclk_o; prev_busy = busy_o;
  end

  task automatic xfer(input int dv, input int len, input int nw, input bit lsb, input bit cpol,
                      input bit txf, input bit rxf, input bit sel,
                      input logic [127:0] txd, input logic [127:0] sld, input bit poke);
    @(negedge clk);
    div_i = 16'(dv); len_m1_i = 5'(len - 1); words_m1_i = 2'(nw - 1);
    lsb_first_i = lsb; cpol_i = cpol; tx_fall_i = txf; rx_fall_i = rxf; ss_sel_i = sel;
    tx_data_i = txd; sl_data = sld; cur_len = len; cur_nw = nw; cur_lsb = lsb;
    @(negedge clk);
    start_i = 1'b1;
    for (int w = 0; w < nw; w++) begin
      q_tx.push_back(txd[w*32 +: 32] & mask_of(len));
      q_rx.push_back(sld[w*32 +: 32] & mask_of(len));
    end
    q_nw.push_back(nw); q_len.push_back(len); q_div.push_back(dv);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    check(ss_n_o[sel] == 1'b0, "R2 chosen select low", ss_n_o, sel ? 2'b01 : 2'b10);
    if (poke) begin
      repeat (7) @(negedge clk);
      tx_data_i = ~txd;
      start_i = 1'b1;       // R9: must be ignored
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o == 1'b1, "R9 busy unaffected", busy_o, 1);
    end
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy_o == 1'b0, "R9 reset busy", busy_o, 0);
    check(irq_o == 1'b0, "R10 reset irq", irq_o, 0);
    check(ss_n_o == 2'b11, "R2 reset selects", ss_n_o, 2'b11);
    check(rx_data_o == '0, "R4 reset rx", rx_data_o[31:0], 0);
    cpol_i = 1'b1;
    @(negedge clk); @(negedge clk);
    check(sclk_o == 1'b1, "R1 idle follows polarity", sclk_o, 1);

    // byte, MSB first, launch falling / sample rising, idle low
    xfer(1, 8, 1, 0, 0, 1, 0, 0, 128'h5A, 128'hC3, 0);
    // full words, four, LSB first, idle high, launch rising / sample falling, select 1
    xfer(0, 32, 4, 1, 1, 0, 1, 1,
         128'h01234567_89ABCDEF_DEADBEEF_F00DCAFE,
         128'hA5A5F00F_13579BDF_2468ACE0_0F1E2D3C, 0);
    // single-bit words, three, both edges rising
    xfer(2, 1, 3, 0, 0, 0, 0, 0, 128'h1_00000000_00000001, 128'h0_00000001_00000001, 0);
    // 13-bit words, two, both edges falling, idle high, start pulse mid-burst
    xfer(3, 13, 2, 0, 1, 1, 1, 1, 128'h1ABC_00001234, 128'h0F0F_00001555, 1);
    // R4: words past the burst read zero after a shorter second burst
    xfer(0, 5, 1, 1, 0, 1, 0, 0, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFF3, 128'h1E, 0);

    // R10 sticky then cleared
    repeat (4) @(negedge clk);
    check(irq_o == 1'b1, "R10 irq stays set", irq_o, 1);
    irq_clr_i = 1'b1;
    @(negedge clk);
    irq_clr_i = 1'b0;
    check(irq_o == 1'b0, "R10 irq cleared", irq_o, 0);
    check(q_nw.size() == 0, "R9 every burst completed", q_nw.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule